// File: doc/BRIEF.md
# Indexed Control/Status Register Bank

This block is the control and status front end of a legacy Ethernet controller. Software reaches four 16-bit control/status registers through two ports. An index port chooses one register. A data port then reads or writes the chosen register. The receive and transmit engines signal finished work with single-cycle pulses. The block combines that work status with the software commands and drives one interrupt request line.

Register 0 is the command/status word, and its fields behave in several ways:

- A group of event flags clears when software writes a one to it.
- Two summary bits are recomputed on every write.
- The interrupt enable bit takes whatever value is written.
- Three command bits are handled in priority order: stop first, then initialise, then start.

Registers 1 and 2 hold the low and high halves of a 32-bit pointer to the initialisation block in memory. That pointer goes out as a plain output. Register 3 is plain storage.

Top module: `csr_index_bank`

## Requirements
- R1: After reset, register 0 reads 0x0004, registers 1 to 3 read 0, the index reads 0, the pointer output is 0 and the interrupt request is low.
- R2: A write with the port select at 1 loads the index only when the value is below 4. A value of 4 or more leaves the index unchanged. A read with the select at 1 returns the index in the low bits and zeros above.
- R3: A read with the select at 0 returns the register chosen by the index, in the same cycle, with no added latency.
- R4: A data write to register 0 with bit 2 set makes register 0 exactly 0x0004 on the next cycle, whatever the other written bits and any engine pulse in that cycle.
- R5: Without bit 2, a written one in any of bits 14 to 8 clears that bit of register 0. A written zero leaves that bit as it was.
- R6: On each register-0 write without bit 2, bit 15 becomes the OR of bits 14, 13, 12 and 8, and bit 7 becomes the OR of bits 14 to 8. Both are taken after the clears of R5 and before the commands of R8 are applied.
- R7: On each register-0 write without bit 2, bit 6 takes the written value of bit 6.
- R8: On each register-0 write without bit 2:
  - A written bit 0 sets bits 0 and 8 and clears bit 2.
  - Otherwise, a written bit 1 sets bits 1, 5 and 4 and clears bit 2.
  - Command bits never clear bits that are already set.
- R9: Data writes to registers 1, 2 and 3 store the written word. The pointer output is register 2 in its upper half and register 1 in its lower half.
- R10: A receive pulse sets bits 10 and 7 of register 0, and a transmit pulse sets bits 9 and 7. A register-0 write in the same cycle is applied after the pulses, so its clears and its recomputation of R6 win.
- R11: The interrupt request is high exactly when bits 7 and 6 of register 0 are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for the selected port |
| busSel | input | 1 | Port select: 0 data port, 1 index port |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data for the selected port (combinational) |
| rintSet | input | 1 | Receive-complete pulse from the receive engine |
| tintSet | input | 1 | Transmit-complete pulse from the transmit engine |
| initPtr | output | 32 | Initialisation-block pointer built from registers 2 and 1 |
| irq | output | 1 | Interrupt request |

## Verification
A wrong index shows at the data port on the very next read, because the read mux has no pipeline. A wrong index also shows when a later data write lands in the wrong register, and that register then differs on readback. A summary bit computed from the wrong set of flags appears as a wrong bit 15 or bit 7 in the cycle after the write that recomputes it. Through bit 7, the same fault turns up on the interrupt line in that same cycle whenever bit 6 is set. The bench therefore compares the read data, the interrupt line and the pointer with a behavioural model after every clock edge. A fault is caught in the first cycle in which it can be seen at the ports.

// File: rtl/csr_index_pkg.sv
package csr_index_pkg;

  localparam int NUM_CSR = 4;
  localparam int IDX_W   = $clog2(NUM_CSR);

  // register 0 bit positions (software and engines depend on them)
  localparam int BIT_ERR  = 15;
  localparam int BIT_BABL = 14;
  localparam int BIT_CERR = 13;
  localparam int BIT_MISS = 12;
  localparam int BIT_MERR = 11;
  localparam int BIT_RINT = 10;
  localparam int BIT_TINT = 9;
  localparam int BIT_IDON = 8;
  localparam int BIT_INTR = 7;
  localparam int BIT_INEA = 6;
  localparam int BIT_RXON = 5;
  localparam int BIT_TXON = 4;
  localparam int BIT_TDMD = 3;
  localparam int BIT_STOP = 2;
  localparam int BIT_STRT = 1;
  localparam int BIT_INIT = 0;

  localparam int FLAG_LO = BIT_IDON;
  localparam int FLAG_HI = BIT_BABL;

  // strobes from control to datapath
  typedef struct packed {
    logic               idxLoad;
    logic [IDX_W-1:0]   idxNext;
    logic [NUM_CSR-1:0] regLoad;
  } csrStrobes_t;

endpackage

// File: rtl/csr_index_ctrl.sv
module csr_index_ctrl
  import csr_index_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              busWr,
  input  logic              busSel,
  input  logic [DATA_W-1:0] busWData,
  input  logic [IDX_W-1:0]  curIdx,
  output csrStrobes_t       strb
);

  localparam logic [DATA_W-1:0] IDX_LIMIT = DATA_W'(NUM_CSR);

  logic idxInRange;
  assign idxInRange = (busWData < IDX_LIMIT);

  always_comb begin
    strb = '0;
    if (busWr && busSel && idxInRange) begin
      strb.idxLoad = 1'b1;
      strb.idxNext = busWData[IDX_W-1:0];
    end
    if (busWr && !busSel) begin
      strb.regLoad[curIdx] = 1'b1;
    end
  end

endmodule

// File: rtl/csr_index_dp.sv
module csr_index_dp
  import csr_index_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  csrStrobes_t         strb,
  input  logic [DATA_W-1:0]   wData,
  input  logic                busSel,
  input  logic                rintSet,
  input  logic                tintSet,
  output logic [IDX_W-1:0]    curIdx,
  output logic [DATA_W-1:0]   rData,
  output logic [2*DATA_W-1:0] initPtr,
  output logic                irq
);

  localparam logic [DATA_W-1:0] STOP_ONLY    = DATA_W'(1) << BIT_STOP;
  localparam logic [DATA_W-1:0] FLAG_MASK    = DATA_W'(16'h7F00);
  localparam logic [DATA_W-1:0] ERR_SRC_MASK = (DATA_W'(1) << BIT_BABL) | (DATA_W'(1) << BIT_CERR)
                                             | (DATA_W'(1) << BIT_MISS) | (DATA_W'(1) << BIT_IDON);

  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] csr0Q;
  logic [DATA_W-1:0] csr0Next;
  logic [DATA_W-1:0] withPulse;
  logic [DATA_W-1:0] afterClr;
  logic [DATA_W-1:0] plainQ [1:NUM_CSR-1];

  // index register
  always_ff @(posedge clk) begin
    if (!rstN)             idxQ <= '0;
    else if (strb.idxLoad) idxQ <= strb.idxNext;
  end
  assign curIdx = idxQ;

  // register 0 next-state: pulses first, then the software write
  always_comb begin
    withPulse = csr0Q;
    if (rintSet) begin
      withPulse[BIT_RINT] = 1'b1;
      withPulse[BIT_INTR] = 1'b1;
    end
    if (tintSet) begin
      withPulse[BIT_TINT] = 1'b1;
      withPulse[BIT_INTR] = 1'b1;
    end
    afterClr = withPulse & ~(wData & FLAG_MASK);
    csr0Next = withPulse;
    if (strb.regLoad[0]) begin
      if (wData[BIT_STOP]) begin
        csr0Next = STOP_ONLY;
      end else begin
        csr0Next           = afterClr;
        csr0Next[BIT_ERR]  = |(afterClr & ERR_SRC_MASK);
        csr0Next[BIT_INTR] = |(afterClr & FLAG_MASK);
        csr0Next[BIT_INEA] = wData[BIT_INEA];
        if (wData[BIT_INIT]) begin
          csr0Next[BIT_INIT] = 1'b1;
          csr0Next[BIT_IDON] = 1'b1;
          csr0Next[BIT_STOP] = 1'b0;
        end else if (wData[BIT_STRT]) begin
          csr0Next[BIT_STRT] = 1'b1;
          csr0Next[BIT_RXON] = 1'b1;
          csr0Next[BIT_TXON] = 1'b1;
          csr0Next[BIT_STOP] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) csr0Q <= STOP_ONLY;
    else       csr0Q <= csr0Next;
  end

  // plain storage registers
  for (genvar g = 1; g < NUM_CSR; g++) begin : gPlain
    always_ff @(posedge clk) begin
      if (!rstN)                plainQ[g] <= '0;
      else if (strb.regLoad[g]) plainQ[g] <= wData;
    end
  end

  // read mux
  always_comb begin
    if (busSel) begin
      rData = DATA_W'(idxQ);
    end else begin
      rData = csr0Q;
      for (int k = 1; k < NUM_CSR; k++) begin
        if (idxQ == IDX_W'(k)) rData = plainQ[k];
      end
    end
  end

  assign initPtr = {plainQ[2], plainQ[1]};
  assign irq     = csr0Q[BIT_INTR] & csr0Q[BIT_INEA];

  // R4
  stop_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regLoad[0] && wData[BIT_STOP]) |=> (csr0Q == STOP_ONLY));

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    csr0Q[BIT_ERR] |-> (|(csr0Q & ERR_SRC_MASK)));

  // R6
  intr_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    csr0Q[BIT_INTR] |-> (|(csr0Q & FLAG_MASK)));

  // R10
  rint_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rintSet && !strb.regLoad[0]) |=> (csr0Q[BIT_RINT] && csr0Q[BIT_INTR]));

  // R8
  init_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regLoad[0] && !wData[BIT_STOP] && wData[BIT_INIT])
      |=> (csr0Q[BIT_INIT] && csr0Q[BIT_IDON] && !csr0Q[BIT_STOP]));

endmodule

// File: rtl/csr_index_bank.sv
module csr_index_bank
  import csr_index_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic                busSel,
  input  logic [DATA_W-1:0]   busWData,
  output logic [DATA_W-1:0]   busRData,
  input  logic                rintSet,
  input  logic                tintSet,
  output logic [2*DATA_W-1:0] initPtr,
  output logic                irq
);

  localparam logic [DATA_W-1:0] IDX_LIMIT = DATA_W'(NUM_CSR);

  csrStrobes_t      strb;
  logic [IDX_W-1:0] curIdx;

  csr_index_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .busWr    (busWr),
    .busSel   (busSel),
    .busWData (busWData),
    .curIdx   (curIdx),
    .strb     (strb)
  );

  csr_index_dp #(.DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wData    (busWData),
    .busSel   (busSel),
    .rintSet  (rintSet),
    .tintSet  (tintSet),
    .curIdx   (curIdx),
    .rData    (busRData),
    .initPtr  (initPtr),
    .irq      (irq)
  );

  // R2
  idx_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel && (busWData >= IDX_LIMIT)) |=> $stable(curIdx));

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel && (busWData < IDX_LIMIT)) |=> (DATA_W'(curIdx) == $past(busWData)));

endmodule

// File: tb/test_csr_index_bank.sv
module test_csr_index_bank;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWr;
  logic        busSel;
  logic [15:0] busWData;
  logic [15:0] busRData;
  logic        rintSet;
  logic        tintSet;
  logic [31:0] initPtr;
  logic        irq;

  always #2 clk = ~clk;

  csr_index_bank i_csr_index_bank (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel),
    .busWData(busWData), .busRData(busRData),
    .rintSet(rintSet), .tintSet(tintSet),
    .initPtr(initPtr), .irq(irq)
  );

  int          checks = 0;
  int          fails  = 0;
  bit          finished = 0;
  logic [15:0] mReg [4];
  int          mIdx;

  function automatic logic [15:0] nextCsr0(logic [15:0] cur, logic [15:0] w,
                                           bit wr, bit rint, bit tint);
    logic [15:0] r;
    bit anyFlag;
    r = cur;
    if (rint) begin r[10] = 1; r[7] = 1; end
    if (tint) begin r[9] = 1; r[7] = 1; end
    if (!wr) return r;
    if (w[2]) return 16'h0004;
    for (int b = 8; b <= 14; b++) if (w[b]) r[b] = 0;
    anyFlag = 0;
    for (int b = 8; b <= 14; b++) if (r[b]) anyFlag = 1;
    r[15] = r[14] | r[13] | r[12] | r[8];
    r[7]  = anyFlag;
    r[6]  = w[6];
    if (w[0]) begin r[0] = 1; r[8] = 1; r[2] = 0; end
    else if (w[1]) begin r[1] = 1; r[5] = 1; r[4] = 1; r[2] = 0; end
    return r;
  endfunction

  task automatic checkVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    logic [15:0] expRd;
    expRd = busSel ? 16'(mIdx) : mReg[mIdx];
    checkVal(tag, "read data", 32'(busRData), 32'(expRd));
    checkVal(tag, "irq", 32'(irq), 32'(mReg[0][7] & mReg[0][6]));
    checkVal(tag, "pointer", initPtr, {mReg[2], mReg[1]});
  endtask

  task automatic step(bit wr, bit sel, logic [15:0] d, bit rint, bit tint, string tag);
    @(negedge clk);
    busWr = wr; busSel = sel; busWData = d; rintSet = rint; tintSet = tint;
    mReg[0] = nextCsr0(mReg[0], d, wr && !sel && mIdx == 0, rint, tint);
    if (wr && !sel && mIdx != 0) mReg[mIdx] = d;
    if (wr && sel && d < 4) mIdx = int'(d);
    @(posedge clk);
    #1;
    compareAll(tag);
  endtask

  task automatic readAll(string tag);
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 16'(i), 0, 0, tag);
      step(0, 0, 16'h0, 0, 0, tag);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; busWr = 0; busSel = 0; busWData = '0; rintSet = 0; tintSet = 0;
    mReg[0] = 16'h0004; mReg[1] = 0; mReg[2] = 0; mReg[3] = 0; mIdx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    compareAll("R1");                       // R1 register 0 and outputs
    busSel = 1; #1;
    compareAll("R1");                       // R1 index at zero

    step(0, 1, 16'h0, 0, 0, "R2");          // R2 index readback
    step(1, 0, 16'h0041, 0, 0, "R8");       // R8 init + R7 enable
    step(1, 0, 16'h0040, 0, 0, "R6");       // R6 summary from IDON, R11 irq high
    step(1, 0, 16'h0140, 0, 0, "R5");       // R5 clear IDON
    step(0, 0, 16'h0, 1, 0, "R10");         // R10 receive pulse
    step(0, 0, 16'h0, 0, 1, "R10");         // R10 transmit pulse
    step(1, 0, 16'h0402, 0, 0, "R7");       // R7 enable dropped, R11 irq low, R8 start
    step(1, 0, 16'h0043, 0, 0, "R8");       // R8 init wins over start
    step(1, 0, 16'h0440, 1, 0, "R10");      // R10 same-cycle write clears pulse
    step(1, 0, 16'h0040, 1, 1, "R10");      // R10 pulses with write keep flags
    step(1, 0, 16'h7F40, 0, 0, "R5");       // R5 clear every flag
    step(1, 0, 16'hFFFF, 1, 1, "R4");       // R4 stop wins over everything
    step(1, 0, 16'h0002, 0, 0, "R8");       // R8 start from stopped

    step(1, 1, 16'h0003, 0, 0, "R2");       // R2 select register 3
    step(1, 0, 16'hBEEF, 0, 0, "R9");       // R9 plain store
    step(1, 1, 16'h0004, 0, 0, "R2");       // R2 out-of-range ignored
    step(1, 1, 16'hFFFF, 0, 0, "R2");       // R2 out-of-range ignored
    step(0, 0, 16'h0, 0, 0, "R3");          // R3 read selected register
    step(1, 1, 16'h0001, 0, 0, "R2");
    step(1, 0, 16'h1234, 0, 0, "R9");       // R9 pointer low half
    step(1, 1, 16'h0002, 0, 0, "R2");
    step(1, 0, 16'hABCD, 1, 0, "R9");       // R9 pointer high half, R10 pulse during other write
    readAll("R3");                          // R3 every register through the index
    step(1, 1, 16'h0000, 0, 0, "R2");
    step(1, 0, 16'h0044, 1, 1, "R4");       // R4 stop with enable and pulses
    step(0, 0, 16'h0, 0, 0, "R11");         // R11 irq follows state

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule